// File: doc/BRIEF.md
# Flash Reprogramming Mode Controller

This block guards an on-chip flash array while software rewrites it. It owns one byte-wide control register on the processor bus. That register holds a mode-enable bit, a region selector and a sticky rejection flag. It also reports whether an operation is in flight and whether the rewrite mode is actually in force. The mode is in force only when the enable bit is set and the programming-supply level, brought in through a synchronizer, reports the high level. The enable bit itself can be changed only while that supply sits at 0 V.

An upstream command decoder presents erase and program commands. The block accepts a command only when the mode is in force, no operation is running, a usable region is selected and, for a program, the target address lies inside that region. An accepted command becomes a one-cycle request toward the flash array. The request carries the address, the data and the bounds of the selected region. The busy flag then stays up until the array reports completion. A refused command raises the sticky flag instead. While the mode is in force, bus reads of flash outside the selected region return 0xFF in place of array contents.

Top module: `flash_reprog_ctrl`

## Requirements
- R1: After reset the register at 0x0FFE reads 0x00 and no array request is raised.
- R2: Register bit 2 (mode monitor) reads 1 only when bit 0 is 1 and the synchronized supply level is 2'b10 (high). With level 2'b00 (0 V) or 2'b01 (low) it reads 0.
- R3: A write to bit 0 takes effect only while the synchronized supply level is 2'b00. At any other level the bit keeps its value.
- R4: The supply-level input passes through two flops. A change on `vpp_level` appears in bit 2 after the second rising clock edge, and not after the first.
- R5: Bit 1 (busy) reads 1 from the cycle after a command is accepted until the cycle after `fl_done`. It stays 1 when the mode drops out during the operation.
- R6: An accepted command raises `fl_req` for exactly one cycle. With it the block presents `fl_erase`, the command address on `fl_addr`, the data on `fl_wdata`, and the region bounds on `fl_lo`/`fl_hi`.
- R7: A program command whose address lies outside the selected region is refused. No request is raised, busy stays 0 and bit 3 becomes 1.
- R8: Bits 5:4 select the erase/program region: 00 gives 0x1000–0xFFFF, 01 gives 0x1000–0x7FFF, 10 gives 0x8000–0xFFFF. An erase presents these bounds on `fl_lo`/`fl_hi`.
- R9: Region code 11 selects nothing. Every erase and program is refused with bit 3 set, and while the mode is in force every flash read returns 0xFF.
- R10: A command issued while the mode is not in force, or while busy is 1, is refused with bit 3 set and raises no request.
- R11: While the mode is in force, a read of 0x1000–0xFFFF outside the selected region returns 0xFF. Reads inside the region, and all flash reads while the mode is off, return `fl_rdata`. Other addresses except 0x0FFE read 0x00.
- R12: Bit 3 is sticky and is cleared by writing 1 to it. Writing 0 leaves it unchanged. A refusal in the same cycle as a clearing write leaves it at 1.
- R13: Bits 7 and 6 always read 0. Writes to bits 7, 6, 2 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vpp_level | input | 2 | Supply level code: 00 = 0 V, 01 = low, 10 = high (asynchronous) |
| bus_addr | input | 16 | Processor bus address, for reads and writes |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmd_valid | input | 1 | One-cycle command strobe from the command decoder |
| cmd_erase | input | 1 | 1 = erase the region, 0 = program one byte |
| cmd_addr | input | 16 | Program target address |
| cmd_data | input | 8 | Program data |
| fl_req | output | 1 | One-cycle request to the flash array |
| fl_erase | output | 1 | Request kind, 1 = erase |
| fl_addr | output | 16 | Request address |
| fl_wdata | output | 8 | Request data |
| fl_lo | output | 16 | Lowest address of the selected region |
| fl_hi | output | 16 | Highest address of the selected region |
| fl_done | input | 1 | Completion pulse from the flash array |
| fl_rd_addr | output | 16 | Read address toward the array |
| fl_rdata | input | 8 | Array read data |

## Verification
Two pairs of events can fall on the same clock edge. A refused command can land in the cycle of a register write that clears the sticky flag. The bench drives both strobes on the same edge and expects the flag to read 1 afterwards. A new command can also arrive while an operation is still running, including the stretch after the supply drops away. The bench issues a second command right after an accepted one and expects no second request and the flag set. It also drops the supply level mid-operation and expects busy to stay up until the array's completion pulse.

// File: rtl/fpr_pkg.sv
// Package: shared encodings for the flash reprogramming mode controller.
// Assumes an 8-bit register layout; bit positions below are read by software.
package fpr_pkg;

    // Synchronized supply-level code
    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;

    // Region selector code held in register bits 5:4
    typedef enum logic [1:0] {
        RGN_FULL  = 2'b00,
        RGN_LOWER = 2'b01,
        RGN_UPPER = 2'b10,
        RGN_NONE  = 2'b11
    } rgn_e;

    localparam int unsigned BIT_SEL    = 0;
    localparam int unsigned BIT_BUSY   = 1;
    localparam int unsigned BIT_MON    = 2;
    localparam int unsigned BIT_ERR    = 3;
    localparam int unsigned BIT_RGN_LO = 4;
    localparam int unsigned BIT_RGN_HI = 5;
    localparam int unsigned REG_BITS   = 6;

endpackage

// File: rtl/fpr_lvl_sync.sv
// Module: multi-flop synchronizer for the supply-level code.
// Assumes the level changes slowly relative to the clock, so bit skew between
// the two code bits settles within one extra cycle. Resets to the 0 V code.
module fpr_lvl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Shift one stage further
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/fpr_region_dec.sv
// Module: region decoder. Turns the two-bit region code into inclusive address
// bounds and a valid flag. The reserved code yields no region.
// Assumes BASE < SPLIT and the flash extends to the top of the address space.
module fpr_region_dec
    import fpr_pkg::*;
#(
    parameter int             AW    = 16,
    parameter logic [AW-1:0]  BASE  = 16'h1000,
    parameter logic [AW-1:0]  SPLIT = 16'h8000
) (
    input  rgn_e          rgn,
    output logic [AW-1:0] lo,
    output logic [AW-1:0] hi,
    output logic          valid
);

    localparam logic [AW-1:0] SPLIT_M1 = AW'(SPLIT - 1);

    // Map region code to bounds
    always_comb begin
        lo    = '0;
        hi    = '0;
        valid = 1'b1;
        case (rgn)
            RGN_FULL:  begin lo = BASE;  hi = '1;       end
            RGN_LOWER: begin lo = BASE;  hi = SPLIT_M1; end
            RGN_UPPER: begin lo = SPLIT; hi = '1;       end
            default:   begin valid = 1'b0;              end
        endcase
    end

endmodule

// File: rtl/fpr_ctl_regs.sv
// Module: control register storage. Holds the mode-enable bit, the region code
// and the sticky refusal flag, and derives the mode-valid indication.
// Assumes the caller decodes the register address into reg_wr.
module fpr_ctl_regs
    import fpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] lvl,
    input  logic       reg_wr,
    input  logic       wr_sel,
    input  logic       wr_err,
    input  logic [1:0] wr_rgn,
    input  logic       reject,
    output logic       mode_sel,
    output logic       mode_valid,
    output logic       err,
    output rgn_e       rgn
);

    logic lvl_zero;
    assign lvl_zero = (lvl == LVL_ZERO);

    // Enable bit: writable only at 0 V
    always_ff @(posedge clk) begin
        if (!rst_n)                  mode_sel <= 1'b0;
        else if (reg_wr && lvl_zero) mode_sel <= wr_sel;
    end

    // Region code: writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n)      rgn <= RGN_FULL;
        else if (reg_wr) rgn <= rgn_e'(wr_rgn);
    end

    // Sticky refusal flag: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                err <= 1'b0;
        else if (reject)           err <= 1'b1;
        else if (reg_wr && wr_err) err <= 1'b0;
    end

    // Mode is in force only when bit and supply level agree
    assign mode_valid = mode_sel && (lvl == LVL_HIGH);

    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_zero |=> $stable(mode_sel)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> err); // R12
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err && !reg_wr |=> err); // R12

endmodule

// File: rtl/fpr_op_seq.sv
// Module: operation sequencer. Qualifies commands, launches one-cycle array
// requests and tracks the busy state until the array reports completion.
// Assumes fl_done arrives only after a request; a stray pulse while idle is
// ignored. The region bounds are latched with each request.
module fpr_op_seq #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_erase,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          cmd_hit,
    input  logic          mode_valid,
    input  logic          rgn_valid,
    input  logic [AW-1:0] rgn_lo,
    input  logic [AW-1:0] rgn_hi,
    input  logic          fl_done,
    output logic          busy,
    output logic          reject,
    output logic          fl_req,
    output logic          fl_erase,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic [AW-1:0] fl_lo,
    output logic [AW-1:0] fl_hi
);

    logic accept;

    // Qualify the incoming command
    always_comb begin
        accept = cmd_valid && mode_valid && !busy && rgn_valid
                 && (cmd_erase || cmd_hit);
        reject = cmd_valid && !accept;
    end

    // Busy: set on launch, cleared by completion
    always_ff @(posedge clk) begin
        if (!rst_n)       busy <= 1'b0;
        else if (accept)  busy <= 1'b1;
        else if (fl_done) busy <= 1'b0;
    end

    // Request strobe, one cycle per accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) fl_req <= 1'b0;
        else        fl_req <= accept;
    end

    // Request payload, latched at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_erase <= 1'b0;
            fl_addr  <= '0;
            fl_wdata <= '0;
            fl_lo    <= '0;
            fl_hi    <= '0;
        end else if (accept) begin
            fl_erase <= cmd_erase;
            fl_addr  <= cmd_addr;
            fl_wdata <= cmd_data;
            fl_lo    <= rgn_lo;
            fl_hi    <= rgn_hi;
        end
    end

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> busy); // R5
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fl_done |=> busy); // R5
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |=> !fl_req); // R6
    AST_PROG_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_erase |-> (fl_addr >= fl_lo) && (fl_addr <= fl_hi)); // R7
    AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !fl_req); // R10

endmodule

// File: rtl/flash_reprog_ctrl.sv
// Module: flash reprogramming mode controller (top). Decodes the control
// register address, assembles register reads, gates flash reads by region,
// and wires the synchronizer, decoder, register and sequencer together.
// Assumes bus reads are combinational and need no strobe; DW is at least 8.
module flash_reprog_ctrl
    import fpr_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            DW         = 8,
    parameter int            SYNC_STAGE = 2,
    parameter logic [AW-1:0] REG_ADDR   = 16'h0FFE,
    parameter logic [AW-1:0] FL_BASE    = 16'h1000,
    parameter logic [AW-1:0] FL_SPLIT   = 16'h8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    vpp_level,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          cmd_valid,
    input  logic          cmd_erase,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    output logic          fl_req,
    output logic          fl_erase,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic [AW-1:0] fl_lo,
    output logic [AW-1:0] fl_hi,
    input  logic          fl_done,
    output logic [AW-1:0] fl_rd_addr,
    input  logic [DW-1:0] fl_rdata
);

    localparam int PAD_W = DW - REG_BITS;

    logic [1:0]    lvl_q;
    logic          reg_sel;
    logic          reg_wr;
    logic          mode_sel;
    logic          mode_valid;
    logic          err;
    rgn_e          rgn;
    logic [AW-1:0] rgn_lo;
    logic [AW-1:0] rgn_hi;
    logic          rgn_valid;
    logic          cmd_hit;
    logic          rd_hit;
    logic          in_flash;
    logic          busy;
    logic          reject;
    logic          unused_wbits;

    fpr_lvl_sync #(.W(2), .STAGES(SYNC_STAGE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (vpp_level),
        .q     (lvl_q)
    );

    fpr_region_dec #(.AW(AW), .BASE(FL_BASE), .SPLIT(FL_SPLIT)) u_rgn (
        .rgn   (rgn),
        .lo    (rgn_lo),
        .hi    (rgn_hi),
        .valid (rgn_valid)
    );

    // Register address decode and window compares
    always_comb begin
        reg_sel  = (bus_addr == REG_ADDR);
        reg_wr   = bus_wr && reg_sel;
        in_flash = (bus_addr >= FL_BASE);
        rd_hit   = rgn_valid && (bus_addr >= rgn_lo) && (bus_addr <= rgn_hi);
        cmd_hit  = rgn_valid && (cmd_addr >= rgn_lo) && (cmd_addr <= rgn_hi);
    end

    assign unused_wbits = ^{bus_wdata[DW-1:BIT_RGN_HI+1],
                            bus_wdata[BIT_MON], bus_wdata[BIT_BUSY]};

    fpr_ctl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl_q),
        .reg_wr     (reg_wr),
        .wr_sel     (bus_wdata[BIT_SEL]),
        .wr_err     (bus_wdata[BIT_ERR]),
        .wr_rgn     (bus_wdata[BIT_RGN_HI:BIT_RGN_LO]),
        .reject     (reject),
        .mode_sel   (mode_sel),
        .mode_valid (mode_valid),
        .err        (err),
        .rgn        (rgn)
    );

    fpr_op_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_erase  (cmd_erase),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .cmd_hit    (cmd_hit),
        .mode_valid (mode_valid),
        .rgn_valid  (rgn_valid),
        .rgn_lo     (rgn_lo),
        .rgn_hi     (rgn_hi),
        .fl_done    (fl_done),
        .busy       (busy),
        .reject     (reject),
        .fl_req     (fl_req),
        .fl_erase   (fl_erase),
        .fl_addr    (fl_addr),
        .fl_wdata   (fl_wdata),
        .fl_lo      (fl_lo),
        .fl_hi      (fl_hi)
    );

    assign fl_rd_addr = bus_addr;

    // Read mux: register, gated flash, or empty space
    always_comb begin
        if (reg_sel)
            bus_rdata = {{PAD_W{1'b0}}, rgn, err, mode_valid, busy, mode_sel};
        else if (in_flash)
            bus_rdata = (mode_valid && !rd_hit) ? '1 : fl_rdata;
        else
            bus_rdata = '0;
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> bus_rdata[DW-1:REG_BITS] == '0); // R13
    AST_MON_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel && bus_rdata[BIT_MON] |-> lvl_q == LVL_HIGH); // R2
    AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        in_flash && !reg_sel && mode_valid && !rgn_valid |-> bus_rdata == '1); // R9

endmodule

// File: tb/flash_reprog_ctrl_bench.sv
module flash_reprog_ctrl_bench;

    localparam logic [15:0] RA  = 16'h0FFE;
    localparam int          LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  vpp_level = 2'b00;
    logic [15:0] bus_addr = 16'h0FFE;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_erase = 1'b0;
    logic [15:0] cmd_addr = 16'h0000;
    logic [7:0]  cmd_data = 8'h00;
    logic        fl_req, fl_erase;
    logic [15:0] fl_addr, fl_lo, fl_hi, fl_rd_addr;
    logic [7:0]  fl_wdata, fl_rdata;
    logic        fl_done = 1'b0;
    int          cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    flash_reprog_ctrl u_flash_reprog_ctrl (
        .clk(clk), .rst_n(rst_n), .vpp_level(vpp_level),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .fl_req(fl_req),
        .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_lo(fl_lo), .fl_hi(fl_hi), .fl_done(fl_done),
        .fl_rd_addr(fl_rd_addr), .fl_rdata(fl_rdata)
    );

    // Behavioural array: content is a fixed function of address
    assign fl_rdata = fl_rd_addr[7:0] ^ fl_rd_addr[15:8] ^ 8'h3C;

    // Fixed-latency completion model
    always @(posedge clk) begin
        fl_done <= 1'b0;
        if (fl_req) cnt <= LAT;
        else if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) fl_done <= 1'b1;
        end
    end

    function automatic logic [7:0] model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        bus_addr = RA; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic set_lvl(input logic [1:0] l);
        @(negedge clk);
        vpp_level = l;
        repeat (2) @(negedge clk);
    endtask

    task automatic issue(input logic e, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = RA; cmd_valid = 1'b1; cmd_erase = e; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        bit idle = 1'b0;
        bus_addr = RA;
        for (int i = 0; i < LAT + 6; i++) begin
            @(negedge clk);
            if (!bus_rdata[1]) begin idle = 1'b1; break; end
        end
        chk(tag, idle, 1'b1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(RA, v);
        chk("R1 reset register", v, 8'h00);
        chk("R1 reset request", fl_req, 1'b0);
    endtask

    task automatic t_ignored_bits();
        logic [7:0] v;
        wr_reg(8'hC6);
        rd(RA, v);
        chk("R13 ignored bits", v, 8'h00);
    endtask

    task automatic t_mode_levels();
        logic [7:0] v;
        wr_reg(8'h11);
        rd(RA, v);
        chk("R2 sel at 0V", v, 8'h11);
        set_lvl(2'b01);
        rd(RA, v);
        chk("R2 sel at low level", v, 8'h11);
        set_lvl(2'b00);
        @(negedge clk);
        vpp_level = 2'b10; bus_addr = RA;
        @(negedge clk);
        chk("R4 one edge after change", bus_rdata[2], 1'b0);
        @(negedge clk);
        chk("R4 two edges after change", bus_rdata[2], 1'b1);
        chk("R2 valid at high", bus_rdata, 8'h15);
    endtask

    task automatic t_sel_lock();
        logic [7:0] v;
        wr_reg(8'h10);
        rd(RA, v);
        chk("R3 write at high ignored", v[0], 1'b1);
        set_lvl(2'b01);
        wr_reg(8'h10);
        rd(RA, v);
        chk("R3 write at low ignored", v[0], 1'b1);
        set_lvl(2'b00);
        wr_reg(8'h10);
        rd(RA, v);
        chk("R3 write at 0V taken", v[0], 1'b0);
        wr_reg(8'h11);
        set_lvl(2'b10);
        rd(RA, v);
        chk("R2 restored valid", v, 8'h15);
    endtask

    task automatic t_program_ok();
        issue(1'b0, 16'h2345, 8'hA5);
        chk("R6 request raised", fl_req, 1'b1);
        chk("R6 kind", fl_erase, 1'b0);
        chk("R6 address", fl_addr, 16'h2345);
        chk("R6 data", fl_wdata, 8'hA5);
        chk("R5 busy after accept", bus_rdata[1], 1'b1);
        @(negedge clk);
        chk("R6 single pulse", fl_req, 1'b0);
        repeat (LAT - 1) @(negedge clk);
        chk("R5 busy during op", bus_rdata[1], 1'b1);
        wait_idle("R5 busy clears after done");
    endtask

    task automatic t_program_outside();
        logic [7:0] v;
        issue(1'b0, 16'h9000, 8'h11);
        chk("R7 no request", fl_req, 1'b0);
        chk("R7 busy stays low", bus_rdata[1], 1'b0);
        chk("R7 error set", bus_rdata[3], 1'b1);
        wr_reg(8'h11);
        rd(RA, v);
        chk("R12 write zero keeps flag", v[3], 1'b1);
        wr_reg(8'h19);
        rd(RA, v);
        chk("R12 write one clears flag", v[3], 1'b0);
    endtask

    task automatic t_erase_regions();
        logic [15:0] lo_e [3];
        logic [15:0] hi_e [3];
        lo_e[0] = 16'h1000; hi_e[0] = 16'hFFFF;
        lo_e[1] = 16'h1000; hi_e[1] = 16'h7FFF;
        lo_e[2] = 16'h8000; hi_e[2] = 16'hFFFF;
        for (int r = 0; r < 3; r++) begin
            wr_reg({2'b00, r[1:0], 4'b0001});
            issue(1'b1, 16'h0000, 8'h00);
            chk("R8 erase request", fl_req, 1'b1);
            chk("R8 erase kind", fl_erase, 1'b1);
            chk("R8 lower bound", fl_lo, lo_e[r]);
            chk("R8 upper bound", fl_hi, hi_e[r]);
            wait_idle("R8 erase completes");
        end
    endtask

    task automatic t_reads();
        logic [7:0] v;
        wr_reg(8'h11);
        rd(16'h2000, v);
        chk("R11 inside lower region", v, model(16'h2000));
        rd(16'h9000, v);
        chk("R11 outside lower region", v, 8'hFF);
        wr_reg(8'h21);
        rd(16'h2000, v);
        chk("R11 outside upper region", v, 8'hFF);
        rd(16'hC0DE, v);
        chk("R11 inside upper region", v, model(16'hC0DE));
        rd(16'h0100, v);
        chk("R11 non-flash address", v, 8'h00);
        set_lvl(2'b01);
        rd(16'h2000, v);
        chk("R11 mode off passes data", v, model(16'h2000));
        set_lvl(2'b10);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr_reg(8'h31);
        rd(16'h4000, v);
        chk("R9 read blocked", v, 8'hFF);
        issue(1'b1, 16'h0000, 8'h00);
        chk("R9 erase refused", fl_req, 1'b0);
        chk("R9 error set", bus_rdata[3], 1'b1);
        wr_reg(8'h39);
        issue(1'b0, 16'h2000, 8'h55);
        chk("R9 program refused", fl_req, 1'b0);
        wr_reg(8'h09);
        rd(RA, v);
        chk("R12 cleared", v[3], 1'b0);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        wr_reg(8'h31);
        @(negedge clk);
        bus_addr = RA; bus_wdata = 8'h39; bus_wr = 1'b1;
        cmd_valid = 1'b1; cmd_erase = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cmd_valid = 1'b0;
        rd(RA, v);
        chk("R12 set wins over clear", v[3], 1'b1);
        wr_reg(8'h09);
    endtask

    task automatic t_refusals();
        logic [7:0] v;
        set_lvl(2'b01);
        issue(1'b1, 16'h0000, 8'h00);
        chk("R10 refused when mode off", fl_req, 1'b0);
        chk("R10 error when mode off", bus_rdata[3], 1'b1);
        wr_reg(8'h09);
        set_lvl(2'b10);
        issue(1'b1, 16'h0000, 8'h00);
        chk("R10 first accepted", fl_req, 1'b1);
        issue(1'b0, 16'h3000, 8'h77);
        chk("R10 refused when busy", fl_req, 1'b0);
        chk("R10 error when busy", bus_rdata[3], 1'b1);
        wait_idle("R10 op completes");
        wr_reg(8'h09);
        rd(RA, v);
        chk("R10 state restored", v, 8'h05);
    endtask

    task automatic t_drop_mid_op();
        issue(1'b0, 16'h1234, 8'h42);
        chk("R5 drop test launch", fl_req, 1'b1);
        set_lvl(2'b00);
        bus_addr = RA;
        #1;
        chk("R5 mode gone", bus_rdata[2], 1'b0);
        chk("R5 busy held after drop", bus_rdata[1], 1'b1);
        wait_idle("R5 busy clears on done after drop");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ignored_bits();
        t_mode_levels();
        t_sel_lock();
        t_program_ok();
        t_program_outside();
        t_erase_regions();
        t_reads();
        t_reserved();
        t_collide();
        t_refusals();
        t_drop_mid_op();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule